// File: doc/BRIEF.md
# Frame-Aligned Data Flow Gate

This block decides, cycle by cycle, whether the decoded disc data stream arriving at a buffer is written. Software programs a one-byte control register. Boundary events come from the upstream decoder as single-cycle strobes: a sync-pattern-found strobe marks data frame boundaries, and an F1 C-flag strobe marks audio frame boundaries. A decoder-active status level arrives with them. The block drives a store-enable level to the buffer write path. It also drives a one-cycle frame-state reset pulse to the frame sequencer and buffer counters, a one-cycle sync-search restart pulse, and a combined ready status that selects between two upstream ready flags.

In data mode, start and stop can wait for the next sync pattern (synchronous selection) or take effect at once (asynchronous selection). An immediate stop is an emergency halt that can leave a partial frame in the buffer. In audio mode, a separate enable bit starts and stops the stream, and changes land only on C-flag boundaries. Audio mode has no immediate stop. A simulated end-of-frame bit blocks all storage while it is set. When software releases it and the decoder is idle, it restores the beginning-of-frame state.

Top module: `flow_gate`

## Requirements
- R1: After reset the control byte is zero (data mode, asynchronous selection, all enables clear). storeEn, frameRst and syncSearchRestart are low, and readyStatus follows hdrReady.
- R2: The control byte is written by regWrEn with regWrData and takes effect at that clock edge. Bit 0 is the data enable, bit 1 selects synchronous (1) or asynchronous (0), bit 2 selects audio mode (1), bit 3 is the red-book enable, bit 4 drives wdDisable, bit 5 drives breakHold, bit 6 is the sync-search restart and bit 7 is the simulated end-of-frame. wdDisable and breakHold follow their bits in the cycle after the write.
- R3: In data mode with synchronous selection, a set data enable makes storeEn rise in the cycle after a syncDet strobe, and not before.
- R4: In data mode with synchronous selection, a cleared data enable keeps storeEn high until a syncDet strobe, and storeEn falls in the cycle after it.
- R5: In data mode with asynchronous selection, the flow state copies the data enable one cycle after the register holds it, whatever syncDet does.
- R6: In audio mode, the flow state takes the value of the red-book enable only in the cycle after a c1FlagDet strobe. syncDet, the data enable and the sync/async bit have no effect.
- R7: A write that clears bit 7 while it was set, with decoderActive low in that cycle, gives a one-cycle frameRst pulse in the next cycle. With decoderActive high, no pulse is produced.
- R8: storeEn is low in every cycle in which bit 7 of the control byte is set.
- R9: readyStatus equals qFrameReady in audio mode and hdrReady in data mode.
- R10: When a boundary strobe and a register write fall in the same cycle, that boundary uses the control value from before the write, and the new value waits for the following boundary.
- R11: A write that clears bit 6 while it was set gives a one-cycle syncSearchRestart pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| syncDet | input | 1 | Sync pattern detected strobe |
| c1FlagDet | input | 1 | F1 C-flag detected strobe |
| decoderActive | input | 1 | Decoder busy status level |
| hdrReady | input | 1 | Header ready flag (data mode) |
| qFrameReady | input | 1 | Q-frame ready flag (audio mode) |
| storeEn | output | 1 | Write enable toward the buffer |
| frameRst | output | 1 | One-cycle frame-state reset pulse |
| syncSearchRestart | output | 1 | One-cycle sync-search restart pulse |
| readyStatus | output | 1 | Mode-selected ready status |
| breakHold | output | 1 | Hold-serial-output-high level |
| wdDisable | output | 1 | Watchdog disable level |

## Verification
The assertions assume that syncDet and c1FlagDet are plain single-cycle level samples that any cycle may carry, and that a control write can land in any cycle, including one that also carries a boundary strobe. They also assume that decoderActive is sampled in the same cycle as the write that releases the end-of-frame bit. The stimulus drives every input only on the falling clock edge, so each strobe is seen by exactly one rising edge. A random phase lets writes, strobes and the decoder status coincide freely, which covers the same-cycle and gating cases that the assertions cover.

// File: rtl/flow_gate_pkg.sv
package flow_gate_pkg;
  localparam int CTRL_W = 8;

  // bit positions inside the control byte
  localparam int B_DATAEN  = 0;
  localparam int B_SYNCSEL = 1;
  localparam int B_AUDIO   = 2;
  localparam int B_REDEN   = 3;
  localparam int B_WDOFF   = 4;
  localparam int B_BREAK   = 5;
  localparam int B_RESTART = 6;
  localparam int B_SIMEOF  = 7;

  typedef struct packed {
    logic dataEn;
    logic syncSel;
    logic audioMode;
    logic redEn;
    logic eofHold;
    logic eofFall;
    logic restartFall;
  } ctrlStrobes_t;
endpackage

// File: rtl/flow_gate_ctrl.sv
module flow_gate_ctrl
  import flow_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              decoderActive,
  output ctrlStrobes_t      strobes,
  output logic              wdDisable,
  output logic              breakHold
);
  logic [CTRL_W-1:0] ctrlQ;

  always_ff @(posedge clk) begin
    if (!rstN)        ctrlQ <= '0;
    else if (regWrEn) ctrlQ <= regWrData;
  end

  // high-to-low transitions seen through register writes
  logic eofFallNow;
  logic restartFallNow;
  assign eofFallNow     = regWrEn && ctrlQ[B_SIMEOF] && !regWrData[B_SIMEOF] && !decoderActive;
  assign restartFallNow = regWrEn && ctrlQ[B_RESTART] && !regWrData[B_RESTART];

  always_comb begin
    strobes.dataEn      = ctrlQ[B_DATAEN];
    strobes.syncSel     = ctrlQ[B_SYNCSEL];
    strobes.audioMode   = ctrlQ[B_AUDIO];
    strobes.redEn       = ctrlQ[B_REDEN];
    strobes.eofHold     = ctrlQ[B_SIMEOF];
    strobes.eofFall     = eofFallNow;
    strobes.restartFall = restartFallNow;
  end

  assign wdDisable = ctrlQ[B_WDOFF];
  assign breakHold = ctrlQ[B_BREAK];
endmodule

// File: rtl/flow_gate_path.sv
module flow_gate_path
  import flow_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         syncDet,
  input  logic         c1FlagDet,
  input  logic         hdrReady,
  input  logic         qFrameReady,
  output logic         storeEn,
  output logic         frameRst,
  output logic         syncSearchRestart,
  output logic         readyStatus,
  output logic         flowState
);
  logic flowQ;
  logic flowNext;

  always_comb begin
    flowNext = flowQ;
    if (strobes.audioMode) begin
      if (c1FlagDet) flowNext = strobes.redEn;
    end else if (strobes.syncSel) begin
      if (syncDet) flowNext = strobes.dataEn;
    end else begin
      flowNext = strobes.dataEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flowQ             <= 1'b0;
      frameRst          <= 1'b0;
      syncSearchRestart <= 1'b0;
    end else begin
      flowQ             <= flowNext;
      frameRst          <= strobes.eofFall;
      syncSearchRestart <= strobes.restartFall;
    end
  end

  assign storeEn     = flowQ && !strobes.eofHold;
  assign readyStatus = strobes.audioMode ? qFrameReady : hdrReady;
  assign flowState   = flowQ;
endmodule

// File: rtl/flow_gate.sv
module flow_gate
  import flow_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              syncDet,
  input  logic              c1FlagDet,
  input  logic              decoderActive,
  input  logic              hdrReady,
  input  logic              qFrameReady,
  output logic              storeEn,
  output logic              frameRst,
  output logic              syncSearchRestart,
  output logic              readyStatus,
  output logic              breakHold,
  output logic              wdDisable
);
  ctrlStrobes_t strobes;
  logic         flowState;

  flow_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .decoderActive(decoderActive), .strobes(strobes),
    .wdDisable(wdDisable), .breakHold(breakHold)
  );

  flow_gate_path u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .syncDet(syncDet),
    .c1FlagDet(c1FlagDet), .hdrReady(hdrReady), .qFrameReady(qFrameReady),
    .storeEn(storeEn), .frameRst(frameRst),
    .syncSearchRestart(syncSearchRestart), .readyStatus(readyStatus),
    .flowState(flowState)
  );
endmodule

// File: rtl/flow_gate_chk.sv
module flow_gate_chk
  import flow_gate_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         regWrEn,
  input logic         syncDet,
  input logic         c1FlagDet,
  input logic         decoderActive,
  input ctrlStrobes_t strobes,
  input logic         flowState,
  input logic         storeEn,
  input logic         frameRst,
  input logic         syncSearchRestart
);
  // R3 / R4: synchronous data mode moves only on a sync strobe
  a_r3_sync_boundary: assert property (@(posedge clk) disable iff (!rstN)
    ((flowState != $past(flowState)) && $past(!strobes.audioMode && strobes.syncSel))
      |-> $past(syncDet));

  // R5: asynchronous data mode copies the enable one cycle later
  a_r5_async_follow: assert property (@(posedge clk) disable iff (!rstN)
    $past(!strobes.audioMode && !strobes.syncSel) |-> (flowState == $past(strobes.dataEn)));

  // R6: audio mode holds its state between C-flags
  a_r6_audio_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.audioMode && !c1FlagDet) |-> (flowState == $past(flowState)));

  // R7: the frame reset pulse needs a write while the decoder is idle
  a_r7_eof_gated: assert property (@(posedge clk) disable iff (!rstN)
    frameRst |-> $past(regWrEn && !decoderActive));

  // R8: nothing is stored while the end-of-frame bit is held
  a_r8_no_store: assert property (@(posedge clk) disable iff (!rstN)
    strobes.eofHold |-> !storeEn);

  // R11: the restart pulse follows a write
  a_r11_restart_write: assert property (@(posedge clk) disable iff (!rstN)
    syncSearchRestart |-> $past(regWrEn));
endmodule

bind flow_gate flow_gate_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .syncDet(syncDet),
  .c1FlagDet(c1FlagDet), .decoderActive(decoderActive), .strobes(strobes),
  .flowState(flowState), .storeEn(storeEn), .frameRst(frameRst),
  .syncSearchRestart(syncSearchRestart)
);

// File: tb/flow_gate_tb.sv
module flow_gate_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic syncDet = 1'b0, c1FlagDet = 1'b0, decoderActive = 1'b0;
  logic hdrReady = 1'b1, qFrameReady = 1'b0;
  logic storeEn, frameRst, syncSearchRestart, readyStatus, breakHold, wdDisable;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  flow_gate u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .syncDet(syncDet), .c1FlagDet(c1FlagDet), .decoderActive(decoderActive),
    .hdrReady(hdrReady), .qFrameReady(qFrameReady), .storeEn(storeEn),
    .frameRst(frameRst), .syncSearchRestart(syncSearchRestart),
    .readyStatus(readyStatus), .breakHold(breakHold), .wdDisable(wdDisable)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model, advanced at each rising edge
  logic [7:0] mCtrl = '0;
  logic mFlow = 0, mFr = 0, mSr = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mCtrl = '0; mFlow = 0; mFr = 0; mSr = 0;
    end else begin
      logic nf;
      nf = mFlow;
      if (mCtrl[2]) begin
        if (c1FlagDet) nf = mCtrl[3];
      end else if (mCtrl[1]) begin
        if (syncDet) nf = mCtrl[0];
      end else begin
        nf = mCtrl[0];
      end
      mFr = regWrEn && mCtrl[7] && !regWrData[7] && !decoderActive;
      mSr = regWrEn && mCtrl[6] && !regWrData[6];
      mFlow = nf;
      if (regWrEn) mCtrl = regWrData;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      string t;
      t = mCtrl[7] ? "R8" : mCtrl[2] ? "R6" : mCtrl[1] ? "R3/R4 sync" : "R5";
      chk(storeEn, mFlow && !mCtrl[7], {t, " model storeEn"});
      chk(frameRst, mFr, "R7 model frameRst");
      chk(syncSearchRestart, mSr, "R11 model restart");
      chk(readyStatus, mCtrl[2] ? qFrameReady : hdrReady, "R9 model ready");
      chk(breakHold, mCtrl[5], "R2 model breakHold");
      chk(wdDisable, mCtrl[4], "R2 model wdDisable");
    end
  end

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic pulseSync();
    @(negedge clk); syncDet = 1'b1;
    @(negedge clk); syncDet = 1'b0;
  endtask

  task automatic pulseC1();
    @(negedge clk); c1FlagDet = 1'b1;
    @(negedge clk); c1FlagDet = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    if (cyc > 60000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(storeEn, 1'b0, "R1 storeEn after reset");
    chk(frameRst, 1'b0, "R1 frameRst after reset");
    chk(readyStatus, 1'b1, "R1 ready follows hdrReady");

    // R3 synchronous start
    wr(8'h03);
    chk(storeEn, 1'b0, "R3 no start before sync");
    idle();
    chk(storeEn, 1'b0, "R3 still waiting");
    pulseSync();
    chk(storeEn, 1'b1, "R3 start after sync");

    // R4 synchronous stop
    wr(8'h02);
    chk(storeEn, 1'b1, "R4 flows until sync");
    pulseSync();
    chk(storeEn, 1'b0, "R4 stop after sync");

    // R10 write and boundary together
    @(negedge clk); regWrEn = 1'b1; regWrData = 8'h03; syncDet = 1'b1;
    @(negedge clk); regWrEn = 1'b0; syncDet = 1'b0;
    chk(storeEn, 1'b0, "R10 same-cycle change deferred");
    pulseSync();
    chk(storeEn, 1'b1, "R10 applied at next sync");

    // R5 asynchronous stop and start
    wr(8'h00);
    chk(storeEn, 1'b1, "R5 one cycle lag");
    idle();
    chk(storeEn, 1'b0, "R5 immediate stop");
    wr(8'h01);
    idle();
    chk(storeEn, 1'b1, "R5 start without sync");

    // R8 / R7 simulated end of frame
    wr(8'h81);
    chk(storeEn, 1'b0, "R8 blocked while bit7 set");
    wr(8'h01);
    chk(frameRst, 1'b1, "R7 pulse on release");
    idle();
    chk(frameRst, 1'b0, "R7 pulse one cycle");
    chk(storeEn, 1'b1, "R8 store resumes");
    decoderActive = 1'b1;
    wr(8'h81);
    wr(8'h01);
    chk(frameRst, 1'b0, "R7 gated by decoderActive");
    decoderActive = 1'b0;

    // R2 level bits, R11 restart pulse
    wr(8'h30);
    chk(breakHold, 1'b1, "R2 bit5 breakHold");
    chk(wdDisable, 1'b1, "R2 bit4 wdDisable");
    wr(8'h40);
    chk(breakHold, 1'b0, "R2 breakHold cleared");
    wr(8'h00);
    chk(syncSearchRestart, 1'b1, "R11 pulse on release");
    idle();
    chk(syncSearchRestart, 1'b0, "R11 pulse one cycle");

    // R6 audio mode, R9 ready select
    wr(8'h0C);
    chk(storeEn, 1'b0, "R6 waits for C-flag");
    pulseSync();
    chk(storeEn, 1'b0, "R6 sync ignored");
    pulseC1();
    chk(storeEn, 1'b1, "R6 start at C-flag");
    wr(8'h05);
    idle();
    chk(storeEn, 1'b1, "R6 no async stop");
    pulseC1();
    chk(storeEn, 1'b0, "R6 stop at C-flag");
    hdrReady = 1'b0; qFrameReady = 1'b1;
    idle();
    chk(readyStatus, 1'b1, "R9 audio selects qFrameReady");
    wr(8'h00);
    chk(readyStatus, 1'b0, "R9 data selects hdrReady");

    // random phase, compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      regWrEn       = ($urandom_range(0, 5) == 0);
      regWrData     = 8'($urandom);
      regWrData[7]  = ($urandom_range(0, 3) == 0);
      syncDet       = ($urandom_range(0, 4) == 0);
      c1FlagDet     = ($urandom_range(0, 4) == 0);
      decoderActive = $urandom_range(0, 1) == 1;
      hdrReady      = $urandom_range(0, 1) == 1;
      qFrameReady   = $urandom_range(0, 1) == 1;
    end
    @(negedge clk);
    regWrEn = 1'b0; syncDet = 1'b0; c1FlagDet = 1'b0;
    idle();
    done = 1;
    summary();
    $finish;
  end
endmodule